// File: doc/BRIEF.md
# Word/Byte Integer ALU with Condition Codes

This block is the purely combinational arithmetic and logic unit of a 16-bit processor datapath. Each cycle the surrounding pipeline presents an operation code, a width flag, the already-fetched source and destination operands and the current condition codes. In the same cycle the block returns the result value, a write-enable saying whether that value should be stored back, and the new negative, zero, overflow and carry flags. Operand fetch, address generation and write-back sit outside the block.

Two-operand operations cover move, compare, bit test, bit clear, bit set, add and subtract. One-operand operations cover clear, complement, increment, decrement, negate, add and subtract carry, test, the four single-bit shifts and rotates, byte swap and sign extend. With the width flag set, most operations work on the low byte only: the flags are taken at bit 7 and the destination's upper byte passes through unchanged. Add, subtract, swap and sign extend always work on the full word.

The block has no clock and no state. Internally a word-wide lane and a byte-wide lane run in parallel, and the width flag picks which lane's result and flags reach the outputs.

Top module: `wb_alu`

## Requirements
- R1: Code 0 (move) gives result_o = src_i with wr_en_o = 1. flags_o and flags_i carry N, Z, V, C at bits 3, 2, 1, 0. N is the result's top bit, Z is set when the result is zero, V is cleared and C is kept from flags_i.
- R2: Code 3 (bit clear) gives (NOT src_i) AND dst_i and code 4 (bit set) gives src_i OR dst_i. Both write (wr_en_o = 1) and set the flags as in R1.
- R3: Code 1 (compare) gives src_i minus dst_i, with C set on borrow and V set on signed overflow. Code 2 (bit test) gives src_i AND dst_i, with V cleared and C kept. Both drive the value on result_o with wr_en_o = 0.
- R4: Code 5 (add) gives dst_i + src_i, with C as the carry out. Code 6 (subtract) gives dst_i minus src_i, with C set on borrow. Both set V on signed overflow, write, and always work on the full word whatever byte_i is.
- R5: With byte_i = 1, every code in 0 to 20 except 5, 6, 19 and 20 works on bits 7:0 alone. N is bit 7, Z tests the low byte, carry and overflow are taken at byte width, and result_o[15:8] equals dst_i[15:8].
- R6: Code 7 (clear) writes zero with N=0, Z=1, V=0, C=0. Code 8 (complement) writes NOT dst_i with V=0, C=1. Code 14 (test) drives dst_i with wr_en_o = 0, V=0, C=0.
- R7: Code 9 (increment) writes dst_i+1 and sets V only when dst_i is the largest positive value. Code 10 (decrement) writes dst_i-1 and sets V only when dst_i is the most negative value. Both keep C.
- R8: Code 11 (negate) writes zero minus dst_i, sets V only when dst_i is the most negative value, and sets C exactly when the result is nonzero.
- R9: Code 12 (add carry) writes dst_i + C, with C set when that addition carries out. Code 13 (subtract carry) writes dst_i minus C, with C set when it borrows. Both set V on signed overflow.
- R10: Code 15 (rotate right) moves bit 0 into C and the incoming C into the top bit. Code 16 (rotate left) moves the top bit into C and the incoming C into bit 0.
- R11: Code 17 (shift right) copies the sign bit into the top position and moves bit 0 into C. Code 18 (shift left) fills bit 0 with zero and moves the top bit into C. For codes 15 to 18, V equals N XOR C of the new flags.
- R12: Code 19 (swap) exchanges the two bytes of dst_i on the full word whatever byte_i is. N and Z come from the low byte of the result, and V and C are cleared.
- R13: Code 20 (sign extend) writes all ones when the incoming N is set and all zeros otherwise, on the full word. N and C are kept, Z is the inverse of the incoming N, and V is cleared.
- R14: Codes 21 to 31 are unassigned. They give wr_en_o = 0, result_o = dst_i and flags_o = flags_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code |
| byte_i | input | 1 | 1 selects a byte-wide operation |
| src_i | input | 16 | Source operand |
| dst_i | input | 16 | Destination operand |
| flags_i | input | 4 | Incoming N, Z, V, C at bits 3..0 |
| result_o | output | 16 | Result value |
| wr_en_o | output | 1 | 1 when the result is to be stored |
| flags_o | output | 4 | New N, Z, V, C at bits 3..0 |

## Verification
Every one of the 32 operation codes is tried at both widths against a grid of operands. The grid includes zero, one, the byte and word sign boundaries (007F, 0080, 7FFF, 8000), all ones and some mixed-byte patterns. These boundary values are what separate correct overflow and borrow from a plain sign test, word carries from byte carries, and a passed-through upper byte from a recomputed one. The four incoming flag patterns (none, all, alternating both ways) show whether C feeds into the carry and rotate operations, whether N drives sign extend, and whether each operation keeps or overwrites the flags it should.

// File: rtl/wb_alu_pkg.sv
package wb_alu_pkg;

    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_MOV  = 5'd0,
        OP_CMP  = 5'd1,
        OP_BIT  = 5'd2,
        OP_BIC  = 5'd3,
        OP_BIS  = 5'd4,
        OP_ADD  = 5'd5,
        OP_SUB  = 5'd6,
        OP_CLR  = 5'd7,
        OP_COM  = 5'd8,
        OP_INC  = 5'd9,
        OP_DEC  = 5'd10,
        OP_NEG  = 5'd11,
        OP_ADC  = 5'd12,
        OP_SBC  = 5'd13,
        OP_TST  = 5'd14,
        OP_ROR  = 5'd15,
        OP_ROL  = 5'd16,
        OP_ASR  = 5'd17,
        OP_ASL  = 5'd18,
        OP_SWAB = 5'd19,
        OP_SXT  = 5'd20
    } op_e;

    // flag vector bit positions
    localparam int FL_N = 3;
    localparam int FL_Z = 2;
    localparam int FL_V = 1;
    localparam int FL_C = 0;

endpackage

// File: rtl/wb_alu_adder.sv
module wb_alu_adder #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         ci_i,
    output logic [W-1:0] sum_o,
    output logic         co_o,
    output logic         ovf_o
);

    logic [W:0] full;

    always_comb begin
        full  = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, ci_i};
        sum_o = full[W-1:0];
        co_o  = full[W];
        ovf_o = (a_i[W-1] == b_i[W-1]) && (full[W-1] != a_i[W-1]);
    end

endmodule

// File: rtl/wb_alu_shifter.sv
module wb_alu_shifter import wb_alu_pkg::*; #(
    parameter int W = 16
) (
    input  op_e          op_i,
    input  logic [W-1:0] d_i,
    input  logic         ci_i,
    output logic [W-1:0] res_o,
    output logic         co_o
);

    always_comb begin
        res_o = d_i;
        co_o  = ci_i;
        case (op_i)
            OP_ROR: begin res_o = {ci_i, d_i[W-1:1]};     co_o = d_i[0];   end
            OP_ROL: begin res_o = {d_i[W-2:0], ci_i};     co_o = d_i[W-1]; end
            OP_ASR: begin res_o = {d_i[W-1], d_i[W-1:1]}; co_o = d_i[0];   end
            OP_ASL: begin res_o = {d_i[W-2:0], 1'b0};     co_o = d_i[W-1]; end
            default: ;
        endcase
    end

endmodule

// File: rtl/wb_alu_lane.sv
module wb_alu_lane import wb_alu_pkg::*; #(
    parameter int W = 16
) (
    input  op_e          op_i,
    input  logic [W-1:0] src_i,
    input  logic [W-1:0] dst_i,
    input  logic [3:0]   flags_i,
    output logic [W-1:0] res_o,
    output logic         wr_o,
    output logic [3:0]   flags_o
);

    localparam int H = W / 2;

    logic [W-1:0] add_a, add_b, sum, sh_res;
    logic         add_ci, co, ovf, sh_co;
    logic         cin, nin;

    assign cin = flags_i[FL_C];
    assign nin = flags_i[FL_N];

    // operand steering onto the single shared adder
    always_comb begin
        add_a  = dst_i;
        add_b  = '0;
        add_ci = 1'b0;
        case (op_i)
            OP_CMP: begin add_a = src_i; add_b = ~dst_i; add_ci = 1'b1; end
            OP_ADD: begin add_b = src_i; end
            OP_SUB: begin add_b = ~src_i; add_ci = 1'b1; end
            OP_INC: begin add_ci = 1'b1; end
            OP_DEC: begin add_b = '1; end
            OP_NEG: begin add_a = '0; add_b = ~dst_i; add_ci = 1'b1; end
            OP_ADC: begin add_ci = cin; end
            OP_SBC: begin add_b = '1; add_ci = ~cin; end
            default: ;
        endcase
    end

    wb_alu_adder #(.W(W)) u_add (
        .a_i(add_a), .b_i(add_b), .ci_i(add_ci),
        .sum_o(sum), .co_o(co), .ovf_o(ovf)
    );

    wb_alu_shifter #(.W(W)) u_sh (
        .op_i(op_i), .d_i(dst_i), .ci_i(cin),
        .res_o(sh_res), .co_o(sh_co)
    );

    always_comb begin
        logic n, z, v, c, own_nz;
        res_o  = dst_i;
        wr_o   = 1'b1;
        v      = 1'b0;
        c      = cin;
        own_nz = 1'b0;
        n      = 1'b0;
        z      = 1'b0;
        flags_o = flags_i;
        unique case (op_i)
            OP_MOV: res_o = src_i;
            OP_CMP: begin res_o = sum; wr_o = 1'b0; v = ovf; c = ~co; end
            OP_BIT: begin res_o = src_i & dst_i; wr_o = 1'b0; end
            OP_BIC: res_o = ~src_i & dst_i;
            OP_BIS: res_o = src_i | dst_i;
            OP_ADD: begin res_o = sum; v = ovf; c = co;  end
            OP_SUB: begin res_o = sum; v = ovf; c = ~co; end
            OP_CLR: begin res_o = '0; c = 1'b0; end
            OP_COM: begin res_o = ~dst_i; c = 1'b1; end
            OP_INC, OP_DEC: begin res_o = sum; v = ovf; end
            OP_NEG: begin res_o = sum; v = ovf; c = |sum; end
            OP_ADC: begin res_o = sum; v = ovf; c = co;  end
            OP_SBC: begin res_o = sum; v = ovf; c = ~co; end
            OP_TST: begin wr_o = 1'b0; c = 1'b0; end
            OP_ROR, OP_ROL, OP_ASR, OP_ASL: begin
                res_o = sh_res;
                c     = sh_co;
                v     = sh_res[W-1] ^ sh_co;
            end
            OP_SWAB: begin
                res_o  = {dst_i[H-1:0], dst_i[W-1:H]};
                c      = 1'b0;
                own_nz = 1'b1;
                n      = dst_i[W-1];
                z      = (dst_i[W-1:H] == '0);
            end
            OP_SXT: begin
                res_o  = nin ? '1 : '0;
                own_nz = 1'b1;
                n      = nin;
                z      = ~nin;
            end
            default: begin
                wr_o = 1'b0;
            end
        endcase
        if (!own_nz) begin
            n = res_o[W-1];
            z = (res_o == '0);
        end
        if (op_i <= OP_SXT) begin
            flags_o = {n, z, v, c};
        end
    end

endmodule

// File: rtl/wb_alu.sv
module wb_alu import wb_alu_pkg::*; #(
    parameter int DATA_W = 16
) (
    input  logic [OP_W-1:0]   op_i,
    input  logic              byte_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic [DATA_W-1:0] dst_i,
    input  logic [3:0]        flags_i,
    output logic [DATA_W-1:0] result_o,
    output logic              wr_en_o,
    output logic [3:0]        flags_o
);

    localparam int BYTE_W  = DATA_W / 2;
    localparam int N_LANES = 2;

    op_e op;
    logic word_only, use_byte;

    logic [DATA_W-1:0] word_res;
    logic [BYTE_W-1:0] byte_res;
    logic [3:0]        word_fl, byte_fl;
    logic              word_wr, byte_wr;

    assign op        = op_e'(op_i);
    assign word_only = (op == OP_ADD) || (op == OP_SUB) ||
                       (op == OP_SWAB) || (op == OP_SXT);
    assign use_byte  = byte_i && !word_only;

    // lane 0 runs at full width, lane 1 at byte width
    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        localparam int LW = (g == 0) ? DATA_W : BYTE_W;
        logic [LW-1:0] res;
        logic          wr;
        logic [3:0]    fl;

        wb_alu_lane #(.W(LW)) u_lane (
            .op_i(op),
            .src_i(src_i[LW-1:0]),
            .dst_i(dst_i[LW-1:0]),
            .flags_i(flags_i),
            .res_o(res),
            .wr_o(wr),
            .flags_o(fl)
        );

        if (g == 0) begin : g_word
            assign word_res = res;
            assign word_wr  = wr;
            assign word_fl  = fl;
        end else begin : g_byte
            assign byte_res = res;
            assign byte_wr  = wr;
            assign byte_fl  = fl;
        end
    end

    always_comb begin
        if (use_byte) begin
            result_o = {dst_i[DATA_W-1:BYTE_W], byte_res};
            wr_en_o  = byte_wr;
            flags_o  = byte_fl;
        end else begin
            result_o = word_res;
            wr_en_o  = word_wr;
            flags_o  = word_fl;
        end
    end

endmodule

// File: rtl/wb_alu_chk.sv
module wb_alu_chk import wb_alu_pkg::*; #(
    parameter int DATA_W = 16
) (
    input logic [OP_W-1:0]   op_i,
    input logic              byte_i,
    input logic [DATA_W-1:0] src_i,
    input logic [DATA_W-1:0] dst_i,
    input logic [3:0]        flags_i,
    input logic [DATA_W-1:0] result_o,
    input logic              wr_en_o,
    input logic [3:0]        flags_o
);

    localparam int BYTE_W = DATA_W / 2;

    logic wide_op;
    assign wide_op = (op_i == OP_ADD) || (op_i == OP_SUB) ||
                     (op_i == OP_SWAB) || (op_i == OP_SXT);

    always_comb begin
        if ((op_i == OP_CMP) || (op_i == OP_BIT) || (op_i == OP_TST)) begin
            // R3
            no_writeback_chk: assert (!wr_en_o)
                else $error("compare/test wrote back");
        end
        if (op_i > OP_SXT) begin
            // R14
            unassigned_op_chk: assert (!wr_en_o && flags_o == flags_i && result_o == dst_i)
                else $error("unassigned code had an effect");
        end
        if (byte_i && !wide_op && op_i <= OP_SXT) begin
            // R5
            upper_byte_keep_chk: assert (result_o[DATA_W-1:BYTE_W] == dst_i[DATA_W-1:BYTE_W])
                else $error("upper byte changed in byte mode");
        end
        if ((op_i == OP_MOV) || (op_i == OP_BIT) || (op_i == OP_BIC) || (op_i == OP_BIS)) begin
            // R2
            logic_flags_chk: assert (!flags_o[FL_V] && flags_o[FL_C] == flags_i[FL_C])
                else $error("logical op disturbed V or C");
        end
        if (op_i >= OP_ROR && op_i <= OP_ASL) begin
            // R11
            shift_v_chk: assert (flags_o[FL_V] == (flags_o[FL_N] ^ flags_o[FL_C]))
                else $error("shift V not N xor C");
        end
        if ((op_i == OP_INC) || (op_i == OP_DEC)) begin
            // R7
            incdec_carry_chk: assert (flags_o[FL_C] == flags_i[FL_C])
                else $error("inc/dec touched C");
        end
    end

endmodule

bind wb_alu wb_alu_chk #(.DATA_W(DATA_W)) u_chk (
    .op_i(op_i), .byte_i(byte_i), .src_i(src_i), .dst_i(dst_i),
    .flags_i(flags_i), .result_o(result_o), .wr_en_o(wr_en_o),
    .flags_o(flags_o)
);

// File: tb/wb_alu_test.sv
`timescale 1ns/1ps
module wb_alu_test;

    localparam int LIMIT = 200000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  op_i = '0;
    logic        byte_i = 1'b0;
    logic [15:0] src_i = '0, dst_i = '0;
    logic [3:0]  flags_i = '0;
    logic [15:0] result_o;
    logic        wr_en_o;
    logic [3:0]  flags_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    wb_alu #(.DATA_W(16)) uut (
        .op_i(op_i), .byte_i(byte_i), .src_i(src_i), .dst_i(dst_i),
        .flags_i(flags_i), .result_o(result_o), .wr_en_o(wr_en_o),
        .flags_o(flags_o)
    );

    logic [15:0] vals [12] = '{16'h0000, 16'h0001, 16'h007F, 16'h0080,
                               16'h00FF, 16'h7FFF, 16'h8000, 16'hFFFF,
                               16'h1234, 16'h80FF, 16'h7F80, 16'hA55A};
    logic [3:0]  fpat [4]  = '{4'h0, 4'hF, 4'h5, 4'hA};

    function automatic string req_of(input int op, input bit b);
        bit wide = (op == 5) || (op == 6) || (op == 19) || (op == 20);
        if (b && !wide && op <= 20) return "R5";
        case (op)
            0: return "R1";
            3, 4: return "R2";
            1, 2: return "R3";
            5, 6: return "R4";
            7, 8, 14: return "R6";
            9, 10: return "R7";
            11: return "R8";
            12, 13: return "R9";
            15, 16: return "R10";
            17, 18: return "R11";
            19: return "R12";
            20: return "R13";
            default: return "R14";
        endcase
    endfunction

    // returns {wr, result[15:0], flags[3:0]}
    function automatic logic [20:0] model(input int op, input bit b,
                                          input logic [15:0] src, input logic [15:0] dst,
                                          input logic [3:0] f);
        bit wide = (op == 5) || (op == 6) || (op == 19) || (op == 20);
        bit byt  = b && !wide;
        logic [31:0] m  = byt ? 32'hFF : 32'hFFFF;
        logic [31:0] sb = byt ? 32'h80 : 32'h8000;
        logic [31:0] s  = {16'h0, src} & m;
        logic [31:0] d  = {16'h0, dst} & m;
        logic [31:0] r  = 0;
        bit cin = f[0], nin = f[3];
        bit wr = 1, n, z, v = 0, c = cin, own = 0;
        logic [15:0] full;
        if (op > 20) return {1'b0, dst, f};
        case (op)
            0: r = s;
            1: begin r = (s - d) & m; wr = 0; c = (s < d); v = ((s ^ d) & (s ^ r) & sb) != 0; end
            2: begin r = s & d; wr = 0; end
            3: r = ~s & d & m;
            4: r = s | d;
            5: begin r = (d + s) & m; c = (d + s) > m; v = (~(d ^ s) & (d ^ r) & sb) != 0; end
            6: begin r = (d - s) & m; c = (d < s); v = ((d ^ s) & (d ^ r) & sb) != 0; end
            7: begin r = 0; c = 0; end
            8: begin r = ~d & m; c = 1; end
            9: begin r = (d + 1) & m; v = (d == sb - 1); end
            10: begin r = (d - 1) & m; v = (d == sb); end
            11: begin r = (0 - d) & m; v = (d == sb); c = (r != 0); end
            12: begin r = (d + cin) & m; v = (d == sb - 1) && cin; c = (d == m) && cin; end
            13: begin r = (d - cin) & m; v = (d == sb) && cin; c = (d == 0) && cin; end
            14: begin r = d; wr = 0; c = 0; end
            15: begin r = (d >> 1) | (cin ? sb : 0); c = d[0]; end
            16: begin r = ((d << 1) & m) | cin; c = (d & sb) != 0; end
            17: begin r = (d >> 1) | (d & sb); c = d[0]; end
            18: begin r = (d << 1) & m; c = (d & sb) != 0; end
            19: begin r = ((d & 32'hFF) << 8) | (d >> 8); c = 0; own = 1;
                      n = r[7]; z = (r & 32'hFF) == 0; end
            default: begin r = nin ? m : 0; own = 1; n = nin; z = !nin; end
        endcase
        if (!own) begin n = (r & sb) != 0; z = (r == 0); end
        if (op >= 15 && op <= 18) v = n ^ c;
        full = byt ? {dst[15:8], r[7:0]} : r[15:0];
        return {wr, full, n, z, v, c};
    endfunction

    task automatic check(input int op, input bit b);
        logic [20:0] exp = model(op, b, src_i, dst_i, flags_i);
        n_cmp++;
        if ({wr_en_o, result_o, flags_o} !== exp) begin
            n_bad++;
            $display("FAIL %s op=%0d byte=%0d src=%h dst=%h fl=%h : got wr=%b res=%h fl=%h, expected wr=%b res=%h fl=%h",
                     req_of(op, b), op, b, src_i, dst_i, flags_i,
                     wr_en_o, result_o, flags_o, exp[20], exp[19:4], exp[3:0]);
        end
    endtask

    initial begin
        repeat (2) @(posedge clk);
        rst = 1'b0;
        // R1..R14: every code at both widths, flags patterns and operand grid
        for (int op = 0; op < 32; op++) begin
            for (int b = 0; b < 2; b++) begin
                for (int fi = 0; fi < 4; fi++) begin
                    for (int si = 0; si < 12; si++) begin
                        for (int di = 0; di < 12; di++) begin
                            @(posedge clk);
                            op_i    = op[4:0];
                            byte_i  = b[0];
                            flags_i = fpat[fi];
                            src_i   = vals[si];
                            dst_i   = vals[di];
                            @(negedge clk);
                            check(op, b[0]);
                        end
                    end
                end
            end
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (LIMIT) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion within %0d cycles", LIMIT);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule